// File: doc/BRIEF.md
# Processor Tick Timer

This block is a free-running cycle timer that sits beside a CPU core. It holds a 32-bit count and a control word. The processor reaches both through a small special-register port with an address, a write strobe, write data and combinational read data. When running, the count advances by one on every CPU clock. The control word carries a 28-bit match period, an interrupt enable, a sticky pending flag and a two-bit run mode.

The unit compares the low 28 bits of the count against the period. On a hit it raises the pending flag. While interrupts are enabled, it then holds a level interrupt to the core until software clears the flag. The run mode selects what the count does on a hit:
- continuous: keep counting
- restart: clear to zero
- one-shot: freeze
- off: the count is halted and never hits

In continuous mode the one counter serves as a monotonic time base and as a one-shot event source at the same time. Software arms the next event by writing a new period together with the mode and enable bits.

A constant register and an output pin both report that the timer is present.

The sequencer is a three-state machine:
- `ST_OFF`: halted.
- `ST_COUNT`: counting and comparing.
- `ST_HOLD`: one-shot hit, count frozen.

Its transitions:
- A control write with run mode 00 goes to `ST_OFF`.
- A control write with any other run mode goes to `ST_COUNT`.
- A hit in one-shot mode moves `ST_COUNT` to `ST_HOLD`.
- Every other case stays in the current state.

Top module: `tick_timer`

## Requirements
- R1: In a running mode the count at address 1 increments by one every clock, wrapping at 32 bits, and reads back all 32 bits.
- R2: The control word at address 0 has the run mode in bits [31:30] (00 off, 01 restart, 10 one-shot, 11 continuous), enable in bit 29, pending in bit 28 and the period in bits [27:0]. The mode, enable and period fields read back as written.
- R3: In continuous mode (11) a hit does not stop or clear the count; it keeps incrementing by one.
- R4: The interrupt output is high exactly when enable and pending are both set. A pending flag with enable clear leaves the output low.
- R5: The pending flag is set on the clock edge after the low 28 count bits equal the period while counting. The upper 4 count bits take no part in the compare.
- R6: Once set, pending stays set until a control write carries 0 in bit 28. Writing 1 to bit 28 neither sets nor clears it. A hit in the same cycle as a clearing write leaves it set.
- R7: A control write holding only run-mode bits (for example 0xC0000000) clears pending and enable and does not disturb the running count.
- R8: In restart mode (01) the count becomes zero on the edge where it hits the period.
- R9: In one-shot mode (10) the count freezes at the period value after a hit. A further control write with a nonzero run mode resumes counting.
- R10: With run mode 00 the count holds its value.
- R11: A write to the count register loads the written value and takes priority over the increment and any hit action in the same cycle.
- R12: Address 2 reads 0x00000001 (timer present), address 3 reads zero, and the present output is constantly 1.
- R13: Reset clears the count and the whole control word, so the timer is off and the interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_addr | input | 2 | Register select: 0 control, 1 count, 2 present, 3 reserved |
| sr_we | input | 1 | Write strobe for the selected register |
| sr_wdata | input | 32 | Write data |
| sr_rdata | output | 32 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Level interrupt request to the core |
| present_o | output | 1 | Timer-present flag, tied high |

## Verification
The assertions assume the address and write strobe are stable across each rising edge. They also assume a write to an unused address is harmless. The bench drives all inputs only on falling edges and writes only to the control and count addresses. It chooses periods and start counts so that each hit falls well inside the waiting windows. A behavioural model updated on every rising edge predicts the read data and the interrupt, and the bench compares them on each cycle. Directed checks with hand-computed constants cover the reset state, the hit actions of each mode, the write priority and the 28-bit compare.

// File: rtl/tick_pkg.sv
package tick_pkg;

    typedef enum logic [1:0] {
        RM_OFF     = 2'b00,
        RM_RESTART = 2'b01,
        RM_ONESHOT = 2'b10,
        RM_CONT    = 2'b11
    } run_mode_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_HOLD  = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/tick_ctrl.sv
module tick_ctrl
    import tick_pkg::*;
#(
    parameter int PER_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  run_mode_e        wr_mode,
    input  run_mode_e        cur_mode,
    input  logic [PER_W-1:0] cnt_low,
    input  logic [PER_W-1:0] period,
    output logic             match_o,
    output logic             inc_o,
    output logic             clr_o,
    output ctl_state_e       state_o
);

    ctl_state_e state_q, state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (mode_we) begin
            state_d = (wr_mode == RM_OFF) ? ST_OFF : ST_COUNT;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_OFF;
                ST_COUNT: if (match_o && cur_mode == RM_ONESHOT) state_d = ST_HOLD;
                ST_HOLD:  state_d = ST_HOLD;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        match_o = 1'b0;
        inc_o   = 1'b0;
        clr_o   = 1'b0;
        unique case (state_q)
            ST_COUNT: begin
                match_o = (cnt_low == period);
                clr_o   = match_o && (cur_mode == RM_RESTART);
                inc_o   = !(match_o && (cur_mode == RM_RESTART || cur_mode == RM_ONESHOT));
            end
            ST_OFF, ST_HOLD: ;
            default: ;
        endcase
    end

    assign state_o = state_q;

    // R9: a frozen one-shot stays frozen until the control word is rewritten
    p_hold_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !mode_we) |=> state_q == ST_HOLD);

endmodule

// File: rtl/tick_count.sv
module tick_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count_o
);

    always_ff @(posedge clk) begin
        if (!rst_n)     count_o <= '0;
        else if (load)  count_o <= load_val;
        else if (clr)   count_o <= '0;
        else if (inc)   count_o <= count_o + 1'b1;
    end

endmodule

// File: rtl/tick_mode.sv
module tick_mode
    import tick_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PER_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             match,
    output run_mode_e        mode_o,
    output logic             ie_o,
    output logic             pend_o,
    output logic [PER_W-1:0] period_o
);

    localparam int IE_BIT   = CNT_W - 3;
    localparam int PEND_BIT = CNT_W - 4;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o   <= RM_OFF;
            ie_o     <= 1'b0;
            pend_o   <= 1'b0;
            period_o <= '0;
        end else begin
            if (we) begin
                mode_o   <= run_mode_e'(wdata[CNT_W-1 -: 2]);
                ie_o     <= wdata[IE_BIT];
                period_o <= wdata[PER_W-1:0];
            end
            pend_o <= match | (we ? (pend_o & wdata[PEND_BIT]) : pend_o);
        end
    end

    // R6: a set flag survives unless software writes a zero over it
    p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !(we && !wdata[PEND_BIT])) |=> pend_o);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PER_W  = 28,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sr_addr,
    input  logic              sr_we,
    input  logic [CNT_W-1:0]  sr_wdata,
    output logic [CNT_W-1:0]  sr_rdata,
    output logic              irq_o,
    output logic              present_o
);

    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_COUNT   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_PRESENT = ADDR_W'(2);
    localparam int IE_BIT   = CNT_W - 3;
    localparam int PEND_BIT = CNT_W - 4;

    logic             ctrl_we, cnt_we;
    logic             match, inc, clr;
    logic             ie, pend;
    logic [PER_W-1:0] period;
    logic [CNT_W-1:0] count;
    run_mode_e        mode;
    ctl_state_e       state;

    assign ctrl_we = sr_we && (sr_addr == A_CTRL);
    assign cnt_we  = sr_we && (sr_addr == A_COUNT);

    tick_ctrl #(.PER_W(PER_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_we(ctrl_we),
        .wr_mode(run_mode_e'(sr_wdata[CNT_W-1 -: 2])), .cur_mode(mode),
        .cnt_low(count[PER_W-1:0]), .period(period),
        .match_o(match), .inc_o(inc), .clr_o(clr), .state_o(state)
    );

    tick_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .load(cnt_we), .load_val(sr_wdata),
        .clr(clr), .inc(inc), .count_o(count)
    );

    tick_mode #(.CNT_W(CNT_W), .PER_W(PER_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(sr_wdata), .match(match),
        .mode_o(mode), .ie_o(ie), .pend_o(pend), .period_o(period)
    );

    always_comb begin
        sr_rdata = '0;
        unique case (sr_addr)
            A_CTRL: begin
                sr_rdata[PER_W-1:0]      = period;
                sr_rdata[PEND_BIT]       = pend;
                sr_rdata[IE_BIT]         = ie;
                sr_rdata[CNT_W-1 -: 2]   = mode;
            end
            A_COUNT:   sr_rdata = count;
            A_PRESENT: sr_rdata[0] = 1'b1;
            default:   sr_rdata = '0;
        endcase
    end

    assign irq_o     = ie & pend;
    assign present_o = 1'b1;

    // R1: counting state with no hit and no load advances by one
    p_run_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && !match && !cnt_we) |=> count == $past(count) + 1'b1);
    // R3: continuous mode runs through a hit
    p_cont_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && match && mode == RM_CONT && !cnt_we) |=> count == $past(count) + 1'b1);
    // R4: a hit with enable set and no control write raises the request
    p_hit_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (match && ie && !ctrl_we) |=> irq_o);
    // R5: every hit leaves the flag set
    p_hit_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> sr_addr != A_CTRL || sr_rdata[PEND_BIT]);
    // R8: restart hit clears the count
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode == RM_RESTART && !cnt_we) |=> count == '0);
    // R9: frozen one-shot count is stable
    p_oneshot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !cnt_we) |=> $stable(count));
    // R10: halted count is stable
    p_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !cnt_we) |=> $stable(count));
    // R11: a load wins over everything else
    p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> count == $past(sr_wdata));
    // R12: present register reads one
    p_present_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_addr == A_PRESENT) |-> sr_rdata == CNT_W'(1));

endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  sr_addr = 2'd0;
    logic        sr_we = 1'b0;
    logic [31:0] sr_wdata = '0;
    logic [31:0] sr_rdata;
    logic        irq_o, present_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer dut (
        .clk(clk), .rst_n(rst_n), .sr_addr(sr_addr), .sr_we(sr_we),
        .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .irq_o(irq_o), .present_o(present_o)
    );

    // behavioural reference
    logic [31:0] m_count;
    logic [1:0]  m_mode;
    logic        m_ie, m_pend, m_stop;
    logic [27:0] m_period;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_count = 0; m_mode = 0; m_ie = 0; m_pend = 0; m_stop = 0; m_period = 0;
        end else begin
            bit run, hit;
            logic [31:0] nc;
            logic np;
            run = !m_stop && m_mode != 2'b00;
            hit = run && (m_count[27:0] == m_period);
            nc  = m_count;
            if (run) begin
                if (hit && m_mode == 2'b01)      nc = 0;
                else if (hit && m_mode == 2'b10) m_stop = 1;
                else                              nc = m_count + 1;
            end
            np = m_pend;
            if (sr_we && sr_addr == 2'd0) begin
                np       = m_pend & sr_wdata[28];
                m_mode   = sr_wdata[31:30];
                m_ie     = sr_wdata[29];
                m_period = sr_wdata[27:0];
                m_stop   = 0;
            end
            if (hit) np = 1;
            if (sr_we && sr_addr == 2'd1) nc = sr_wdata;
            m_count = nc;
            m_pend  = np;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            logic [31:0] e;
            check("R4 irq vs model", {31'd0, irq_o}, {31'd0, m_ie & m_pend});
            case (sr_addr)
                2'd0: begin
                    e = {m_mode, m_ie, m_pend, m_period};
                    check("R2 control vs model", sr_rdata, e);
                end
                2'd1: check("R1 count vs model", sr_rdata, m_count);
                2'd2: check("R12 present vs model", sr_rdata, 32'd1);
                default: check("R12 reserved vs model", sr_rdata, 32'd0);
            endcase
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        sr_addr = a; sr_we = 1'b1; sr_wdata = d;
        @(negedge clk);
        sr_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        sr_addr = a;
        #1;
        v = sr_rdata;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R13 reset state
        rd(2'd1, v); check("R13 count after reset", v, 32'h0);
        rd(2'd0, v); check("R13 control after reset", v, 32'h0);
        check("R13 irq after reset", {31'd0, irq_o}, 32'd0);

        // R12 present
        rd(2'd2, v); check("R12 present register", v, 32'h1);
        rd(2'd3, v); check("R12 reserved register", v, 32'h0);
        check("R12 present pin", {31'd0, present_o}, 32'd1);

        // R10/R11 halted count loads and holds
        wr(2'd1, 32'd100);
        rd(2'd1, v); check("R11 load while off", v, 32'd100);
        tick(3);
        rd(2'd1, v); check("R10 off holds count", v, 32'd100);

        // R2 field readback
        wr(2'd1, 32'h0000_1000);
        wr(2'd0, 32'hE000_0123);
        rd(2'd0, v); check("R2 control readback", v, 32'hE000_0123);

        // R11 load priority while running
        wr(2'd1, 32'd50);
        rd(2'd1, v); check("R11 load beats increment", v, 32'd50);

        // R5/R4/R3 28-bit compare in continuous mode
        wr(2'd1, 32'hF000_0005);
        wr(2'd0, 32'hE000_0008);
        tick(10);
        rd(2'd0, v); check("R5 pending after low-bit hit", {31'd0, v[28]}, 32'd1);
        check("R4 irq with enable and pending", {31'd0, irq_o}, 32'd1);
        rd(2'd1, v); check("R5 upper bits untouched", {28'd0, v[31:28]}, 32'hF);
        tick(1);
        rd(2'd1, v2); check("R3 continuous keeps counting", v2, v + 1);

        // R6 writing 1 keeps it set
        wr(2'd0, 32'hF000_0008);
        rd(2'd0, v); check("R6 write 1 keeps pending", {31'd0, v[28]}, 32'd1);

        // R7 ack write
        wr(2'd0, 32'hC000_0000);
        rd(2'd0, v); check("R7 ack clears pending and enable", v, 32'hC000_0000);
        check("R7 irq low after ack", {31'd0, irq_o}, 32'd0);
        rd(2'd1, v); tick(1); rd(2'd1, v2);
        check("R7 count undisturbed", v2, v + 1);

        // R6 writing 1 does not set
        wr(2'd0, 32'hD0FF_0000);
        rd(2'd0, v); check("R6 write 1 does not set", {31'd0, v[28]}, 32'd0);

        // R4 pending without enable
        wr(2'd1, 32'd0);
        wr(2'd0, 32'hC000_0003);
        tick(8);
        rd(2'd0, v); check("R4 pending set", {31'd0, v[28]}, 32'd1);
        check("R4 irq low without enable", {31'd0, irq_o}, 32'd0);

        // R8 restart
        wr(2'd1, 32'd0);
        wr(2'd0, 32'h6000_000A);
        tick(30);
        rd(2'd1, v); check("R8 restart stays within period", {31'd0, v <= 32'd10}, 32'd1);
        rd(2'd0, v); check("R8 restart hit pends", {31'd0, v[28]}, 32'd1);

        // R9 one-shot
        wr(2'd1, 32'd0);
        wr(2'd0, 32'hA000_0006);
        tick(20);
        rd(2'd1, v); check("R9 one-shot freezes at period", v, 32'd6);
        tick(3);
        rd(2'd1, v); check("R9 one-shot stays frozen", v, 32'd6);
        wr(2'd0, 32'hA000_0009);
        tick(10);
        rd(2'd1, v); check("R9 rearm resumes and refreezes", v, 32'd9);

        // R1 wrap at 32 bits
        wr(2'd0, 32'hC000_0000);
        wr(2'd1, 32'hFFFF_FFFE);
        tick(2);
        rd(2'd1, v); check("R1 count wraps", v, 32'd0);

        tick(2);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule